// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address-Mark Wakeup

This block receives asynchronous serial characters. Each character has one start bit, eight or nine data bits and one stop bit. The block advances only on a receive tick enable that arrives sixteen times per bit period. It finds the falling edge of the start bit and confirms it with three early samples. It then takes three samples near the middle of each data bit and of the stop bit and resolves each bit by majority. When any bit's samples disagree it raises a noise flag. When the stop bit resolves low it raises a framing flag. A completed character is held in an output register until a read strobe frees it, and an overrun flag marks a character that arrived while the register was still full.

The stop-bit decision is made at tick 10 of the stop bit. After that decision the receiver looks for a new start edge at once. An 8-bit character is therefore finished 154 ticks after its start edge, and a 9-bit character after 170. A transmitter running up to about 3.9 % fast (8-bit) or 3.5 % fast (9-bit) is still received cleanly.

On a shared line a standby request parks the receiver. In standby, completed characters leave the data and every flag untouched. If address-mark wake mode is on, a character whose top data bit is 1 ends standby and is delivered like any other character.

Top module: `ovs_rx`

## Requirements
- R1: A bit period is 16 ticks. Data bits and the stop bit are sampled at ticks 8, 9 and 10 of their period and resolved by 2-of-3 majority. Data bits arrive least significant bit first, so the first data bit lands in `rx_data[0]`.
- R2: A start edge is the first tick that sees the line low after a tick that saw it high, and that tick counts as tick 1. The line must also be low at ticks 3, 5 and 7. If it is not, the receiver returns to idle and no output changes.
- R3: With `word9` = 0 a character has 8 data bits and `rx_data[8]` reads 0. With `word9` = 1 it has 9 data bits. `word9` is taken at the start edge.
- R4: If the three samples of any data bit or of the stop bit are not all equal, `noise_err` is set along with the delivered character, whose bits still follow the majority.
- R5: If the stop bit resolves to 0, `frame_err` is set along with the delivered character.
- R6: A stop bit that is high only through tick 10 is accepted without error. A new start edge on the very next tick (tick 11 of the stop period) begins the next character, which is also received without error.
- R7: A one-cycle `rd_stb` clears `rx_full`, `noise_err`, `frame_err` and `overrun_err`.
- R8: If a character completes while `rx_full` is set and no read is taking place, `overrun_err` is set, `rx_data` keeps the older character and the noise and framing flags are not changed.
- R9: If a character completes in the same cycle as `rd_stb`, the new character is loaded, `rx_full` stays set and `overrun_err` is 0.
- R10: A one-cycle `standby_req` sets `standby`. While `standby` is set, a completed character that does not wake the receiver changes neither `rx_data` nor any flag.
- R11: With `addr_wake` = 1, a character in standby whose top data bit is 1 clears `standby` and is delivered with `rx_full` set. The top bit is bit 7 in 8-bit mode and bit 8 in 9-bit mode. With `addr_wake` = 0 no character ends standby.
- R12: After reset, `rx_data` is 0 and `rx_full`, `noise_err`, `frame_err`, `overrun_err` and `standby` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_tick | input | 1 | Receive tick enable, 16 per bit period |
| rx_line | input | 1 | Serial input line, idle high |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| addr_wake | input | 1 | 1 lets an address mark end standby |
| standby_req | input | 1 | One-cycle strobe that enters standby |
| rd_stb | input | 1 | One-cycle read strobe that frees the data register |
| rx_data | output | DW (9) | Last delivered character |
| rx_full | output | 1 | Data register holds an unread character |
| noise_err | output | 1 | Sample disagreement in the delivered character |
| frame_err | output | 1 | Stop bit of the delivered character resolved low |
| overrun_err | output | 1 | A character was lost because the register was full |
| standby | output | 1 | Receiver is in standby |

## Verification
A character can complete in the same clock cycle as the read strobe that empties the data register. The bench pins the read strobe to the exact cycle after the stop-bit vote tick of a fast character. It then expects the new character in the register, the full flag still set and no overrun. A design that applies the read after the load instead would either lose the new character or flag an overrun. The bench also makes a character complete in standby with a mark present and with no mark. It checks whether the flags moved at all.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/ovs_rx_vote.sv
// Combinational vote over a set of line samples.
module ovs_rx_vote #(
   parameter int NS = 3
) (
   input  logic [NS-1:0] smp,
   output logic          maj,
   output logic          mixed
);
   initial begin
      assert (NS >= 3 && (NS % 2) == 1)
         else $fatal(1, "ovs_rx_vote: NS must be odd and at least 3");
   end

   generate
      if (NS == 3) begin : g_three
         assign maj = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
      end else begin : g_count
         int ones;
         always_comb begin
            ones = 0;
            for (int i = 0; i < NS; i++) ones += int'(smp[i]);
         end
         assign maj = (ones > NS / 2);
      end
   endgenerate

   assign mixed = (|smp) & ~(&smp);
endmodule

// File: rtl/ovs_rx_frame.sv
// Character framing: start detection, bit timing, sampling, assembly.
module ovs_rx_frame
   import ovs_rx_pkg::*;
#(
   parameter int OSR = 16,
   parameter int DW  = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          line,
   input  logic          word9,
   output logic          done,
   output logic [DW-1:0] cdata,
   output logic          cnoise,
   output logic          cframe,
   output logic          cw9
);
   localparam int CW = $clog2(OSR + 1);
   localparam int BW = (DW > 2) ? $clog2(DW) : 1;
   localparam logic [CW-1:0] T_S0  = CW'(OSR / 2);
   localparam logic [CW-1:0] T_S1  = CW'(OSR / 2 + 1);
   localparam logic [CW-1:0] T_S2  = CW'(OSR / 2 + 2);
   localparam logic [CW-1:0] T_C0  = CW'(OSR / 2 - 5);
   localparam logic [CW-1:0] T_C1  = CW'(OSR / 2 - 3);
   localparam logic [CW-1:0] T_C2  = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] T_END = CW'(OSR);
   localparam logic [BW-1:0] B_LONG  = BW'(DW - 1);
   localparam logic [BW-1:0] B_SHORT = BW'(DW - 2);

   initial begin
      assert (OSR >= 12 && (OSR % 2) == 0)
         else $fatal(1, "ovs_rx_frame: OSR must be even and at least 12");
      assert (DW >= 2)
         else $fatal(1, "ovs_rx_frame: DW must be at least 2");
   end

   rx_state_e      st;
   logic [CW-1:0]  tcnt;
   logic [CW-1:0]  nt;
   logic [BW-1:0]  bidx;
   logic [BW-1:0]  last_idx;
   logic [1:0]     smp_q;
   logic [2:0]     smp_vec;
   logic           prev_line;
   logic           nacc;
   logic           w9_q;
   logic [DW-1:0]  shreg;
   logic           maj;
   logic           mixed;
   logic           is_chk;

   assign nt       = tcnt + 1'b1;
   assign last_idx = w9_q ? B_LONG : B_SHORT;
   assign smp_vec  = {line, smp_q[1], smp_q[0]};
   assign is_chk   = (nt == T_C0) || (nt == T_C1) || (nt == T_C2);

   ovs_rx_vote #(.NS(3)) u_vote (
      .smp   (smp_vec),
      .maj   (maj),
      .mixed (mixed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         tcnt      <= '0;
         bidx      <= '0;
         smp_q     <= '0;
         prev_line <= 1'b1;
         nacc      <= 1'b0;
         w9_q      <= 1'b0;
         shreg     <= '0;
         done      <= 1'b0;
         cnoise    <= 1'b0;
         cframe    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: begin
                  prev_line <= line;
                  if (prev_line && !line) begin
                     st    <= RX_START;
                     tcnt  <= CW'(1);
                     shreg <= '0;
                     nacc  <= 1'b0;
                     w9_q  <= word9;
                  end
               end
               RX_START: begin
                  tcnt <= nt;
                  if (is_chk && line) begin
                     st        <= RX_IDLE;
                     prev_line <= 1'b1;
                  end else if (nt == T_END) begin
                     tcnt <= '0;
                     bidx <= '0;
                     st   <= RX_DATA;
                  end
               end
               RX_DATA: begin
                  tcnt <= nt;
                  if (nt == T_S0) smp_q[0] <= line;
                  if (nt == T_S1) smp_q[1] <= line;
                  if (nt == T_S2) begin
                     shreg[bidx] <= maj;
                     nacc        <= nacc | mixed;
                  end
                  if (nt == T_END) begin
                     tcnt <= '0;
                     if (bidx == last_idx) st <= RX_STOP;
                     else                  bidx <= bidx + 1'b1;
                  end
               end
               RX_STOP: begin
                  tcnt <= nt;
                  if (nt == T_S0) smp_q[0] <= line;
                  if (nt == T_S1) smp_q[1] <= line;
                  if (nt == T_S2) begin
                     done      <= 1'b1;
                     cnoise    <= nacc | mixed;
                     cframe    <= ~maj;
                     st        <= RX_IDLE;
                     prev_line <= line;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   assign cdata = shreg;
   assign cw9   = w9_q;
endmodule

// File: rtl/ovs_rx_flags.sv
// Holding register, status flags and standby control.
module ovs_rx_flags #(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic [DW-1:0] cdata,
   input  logic          cnoise,
   input  logic          cframe,
   input  logic          cw9,
   input  logic          addr_wake,
   input  logic          standby_req,
   input  logic          rd_stb,
   output logic [DW-1:0] data_o,
   output logic          full_o,
   output logic          noise_o,
   output logic          frame_o,
   output logic          ovr_o,
   output logic          standby_o
);
   logic          msb;
   logic          wake_hit;
   logic          accept;
   logic [DW-1:0] dat_c;
   logic          full_c;
   logic          nz_c;
   logic          fe_c;
   logic          ov_c;
   logic          sb_c;

   assign msb      = cw9 ? cdata[DW-1] : cdata[DW-2];
   assign wake_hit = done & standby_o & addr_wake & msb;
   assign accept   = done & (~standby_o | wake_hit);

   always_comb begin
      dat_c  = data_o;
      full_c = full_o  & ~rd_stb;
      nz_c   = noise_o & ~rd_stb;
      fe_c   = frame_o & ~rd_stb;
      ov_c   = ovr_o   & ~rd_stb;
      if (accept) begin
         if (full_c) begin
            ov_c = 1'b1;
         end else begin
            dat_c  = cdata;
            full_c = 1'b1;
            nz_c   = cnoise;
            fe_c   = cframe;
         end
      end
      if (standby_req)   sb_c = 1'b1;
      else if (wake_hit) sb_c = 1'b0;
      else               sb_c = standby_o;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_o    <= '0;
         full_o    <= 1'b0;
         noise_o   <= 1'b0;
         frame_o   <= 1'b0;
         ovr_o     <= 1'b0;
         standby_o <= 1'b0;
      end else begin
         data_o    <= dat_c;
         full_o    <= full_c;
         noise_o   <= nz_c;
         frame_o   <= fe_c;
         ovr_o     <= ov_c;
         standby_o <= sb_c;
      end
   end
endmodule

// File: rtl/ovs_rx.sv
// Top: oversampled serial receiver with address-mark wakeup.
module ovs_rx #(
   parameter int OSR = 16,
   parameter int DW  = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_tick,
   input  logic          rx_line,
   input  logic          word9,
   input  logic          addr_wake,
   input  logic          standby_req,
   input  logic          rd_stb,
   output logic [DW-1:0] rx_data,
   output logic          rx_full,
   output logic          noise_err,
   output logic          frame_err,
   output logic          overrun_err,
   output logic          standby
);
   logic          chr_done;
   logic [DW-1:0] chr_data;
   logic          chr_noise;
   logic          chr_frame;
   logic          chr_w9;

   ovs_rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (rx_tick),
      .line   (rx_line),
      .word9  (word9),
      .done   (chr_done),
      .cdata  (chr_data),
      .cnoise (chr_noise),
      .cframe (chr_frame),
      .cw9    (chr_w9)
   );

   ovs_rx_flags #(.DW(DW)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (chr_done),
      .cdata       (chr_data),
      .cnoise      (chr_noise),
      .cframe      (chr_frame),
      .cw9         (chr_w9),
      .addr_wake   (addr_wake),
      .standby_req (standby_req),
      .rd_stb      (rd_stb),
      .data_o      (rx_data),
      .full_o      (rx_full),
      .noise_o     (noise_err),
      .frame_o     (frame_err),
      .ovr_o       (overrun_err),
      .standby_o   (standby)
   );
endmodule

// File: rtl/ovs_rx_chk.sv
// Assertion checker bound to the receiver top.
module ovs_rx_chk #(
   parameter int DW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_stb,
   input logic          standby_req,
   input logic          addr_wake,
   input logic          done,
   input logic [DW-1:0] rx_data,
   input logic          rx_full,
   input logic          noise_err,
   input logic          frame_err,
   input logic          overrun_err,
   input logic          standby
);
   // R7
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !done) |=> (!rx_full && !noise_err && !frame_err && !overrun_err));

   // R10
   sb_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby_req |=> standby);

   // R10
   sb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && standby && !addr_wake && !rd_stb) |=> ($stable(rx_full) && $stable(rx_data)));

   // R8
   ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_full && !rd_stb && !standby) |=> (overrun_err && $stable(rx_data)));

   // R9
   rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rd_stb && !standby) |=> (rx_full && !overrun_err));

   // R11
   wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(standby) |-> ($past(done) && $past(addr_wake) && rx_full));

   // R4
   err_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (noise_err || frame_err) |-> rx_full);
endmodule

bind ovs_rx ovs_rx_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_stb      (rd_stb),
   .standby_req (standby_req),
   .addr_wake   (addr_wake),
   .done        (chr_done),
   .rx_data     (rx_data),
   .rx_full     (rx_full),
   .noise_err   (noise_err),
   .frame_err   (frame_err),
   .overrun_err (overrun_err),
   .standby     (standby)
);

// File: tb/sim_ovs_rx.sv
module sim_ovs_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       line = 1'b1;
   logic       word9 = 1'b0;
   logic       addr_wake = 1'b0;
   logic       standby_req = 1'b0;
   logic       rd_stb = 1'b0;
   logic [8:0] rx_data;
   logic       rx_full, noise_err, frame_err, overrun_err, standby;

   int n_chk = 0;
   int n_fail = 0;

   ovs_rx #(.OSR(16), .DW(9)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_tick(tick), .rx_line(line),
      .word9(word9), .addr_wake(addr_wake), .standby_req(standby_req),
      .rd_stb(rd_stb), .rx_data(rx_data), .rx_full(rx_full),
      .noise_err(noise_err), .frame_err(frame_err),
      .overrun_err(overrun_err), .standby(standby)
   );

   initial forever #10 clk = ~clk;

   // vector: w9 | data[9] | glitch bit[4] (15 none) | stop | fast | exp data[9] | exp noise | exp frame
   localparam logic [26:0] VECS [0:7] = '{
      {1'b0, 9'h0A5, 4'd15, 1'b1, 1'b0, 9'h0A5, 1'b0, 1'b0},  // R1 plain
      {1'b0, 9'h13C, 4'd15, 1'b1, 1'b0, 9'h03C, 1'b0, 1'b0},  // R3 bit 8 not sent
      {1'b1, 9'h1C3, 4'd15, 1'b1, 1'b0, 9'h1C3, 1'b0, 1'b0},  // R3 nine bits
      {1'b0, 9'h055, 4'd3,  1'b1, 1'b0, 9'h055, 1'b1, 1'b0},  // R4 data glitch
      {1'b0, 9'h0F0, 4'd15, 1'b0, 1'b0, 9'h0F0, 1'b0, 1'b1},  // R5 low stop
      {1'b1, 9'h101, 4'd8,  1'b1, 1'b0, 9'h101, 1'b1, 1'b0},  // R4 glitch on bit 8
      {1'b0, 9'h080, 4'd15, 1'b1, 1'b1, 9'h080, 1'b0, 1'b0},  // R6 fast stop
      {1'b0, 9'h03E, 4'd8,  1'b1, 1'b0, 9'h03E, 1'b1, 1'b0}   // R4 stop glitch
   };

   function automatic logic [15:0] stat();
      return {2'b00, standby, rx_full, noise_err, frame_err, overrun_err, rx_data};
   endfunction

   function automatic logic [15:0] expv(input logic sb, input logic f, input logic n,
                                        input logic fe, input logic o, input logic [8:0] d);
      return {2'b00, sb, f, n, fe, o, d};
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic hold(input logic v, input int n);
      line = v;
      for (int i = 0; i < n; i++) do_tick();
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic rd();
      @(negedge clk) rd_stb = 1'b1;
      @(negedge clk) rd_stb = 1'b0;
   endtask

   // rd_end is only meaningful with fast = 1: the read lands in the cycle after the stop vote tick
   task automatic send_char(input logic w9, input logic [8:0] d, input int gbit,
                            input logic stopv, input logic fast, input int lead,
                            input logic rd_end);
      int nb;
      word9 = w9;
      nb = w9 ? 9 : 8;
      hold(1'b1, lead);
      hold(1'b0, 16);
      for (int b = 0; b <= nb; b++) begin
         logic v;
         int n;
         v = (b < nb) ? d[b] : stopv;
         n = (b == nb && fast) ? 10 : 16;
         if (b == gbit) begin
            hold(v, 8);
            hold(~v, 1);
            hold(v, n - 9);
         end else begin
            hold(v, n);
         end
      end
      if (rd_end) begin
         rd_stb = 1'b1;
         @(negedge clk) rd_stb = 1'b0;
      end
      line = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 reset", stat(), 16'h0000);

      // R1 R3 R4 R5 R6 vector walk
      for (int i = 0; i < 8; i++) begin
         logic [26:0] v;
         v = VECS[i];
         send_char(v[26], v[25:17], int'(v[16:13]), v[12], v[11], 2, 1'b0);
         settle();
         chk($sformatf("R1/R3/R4/R5/R6 vector %0d", i), stat(),
             expv(1'b0, 1'b1, v[1], v[0], 1'b0, v[10:2]));
         rd();
      end
      // R7 read clears flags
      chk("R7 cleared after read", stat() & 16'h1E00, 16'h0000);

      // R2 false start: line back high by tick 3
      hold(1'b1, 2);
      hold(1'b0, 2);
      hold(1'b1, 20);
      settle();
      chk("R2 false start ignored", stat() & 16'h1E00, 16'h0000);
      send_char(1'b0, 9'h05A, 15, 1'b1, 1'b0, 2, 1'b0);
      settle();
      chk("R2 recovered after false start", stat(), expv(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h05A));
      rd();

      // R6 back-to-back fast characters, new start at tick 11 of stop
      send_char(1'b0, 9'h03C, 15, 1'b1, 1'b1, 2, 1'b0);
      settle();
      chk("R6 first fast char", stat(), expv(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h03C));
      rd();
      send_char(1'b0, 9'h0C3, 15, 1'b1, 1'b1, 0, 1'b0);
      settle();
      chk("R6 second char on tick 11", stat(), expv(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0C3));
      rd();

      // R8 overrun keeps the older data
      send_char(1'b0, 9'h011, 15, 1'b1, 1'b0, 2, 1'b0);
      settle();
      send_char(1'b0, 9'h022, 3, 1'b0, 1'b0, 2, 1'b0);
      settle();
      chk("R8 overrun keeps old", stat(), expv(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 9'h011));
      rd();
      chk("R7 overrun cleared", stat() & 16'h1E00, 16'h0000);

      // R9 completion in the same cycle as a read
      send_char(1'b0, 9'h044, 15, 1'b1, 1'b0, 2, 1'b0);
      settle();
      send_char(1'b0, 9'h099, 15, 1'b1, 1'b1, 2, 1'b1);
      settle();
      chk("R9 read and load same cycle", stat(), expv(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h099));
      rd();

      // R10 standby suppresses delivery
      @(negedge clk) standby_req = 1'b1;
      @(negedge clk) standby_req = 1'b0;
      chk("R10 standby entered", stat(), expv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h099));
      addr_wake = 1'b0;
      send_char(1'b0, 9'h0F1, 15, 1'b1, 1'b0, 2, 1'b0);
      settle();
      chk("R10 no delivery without wake mode", stat(), expv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h099));

      // R11 address-mark wake, 8-bit
      addr_wake = 1'b1;
      send_char(1'b0, 9'h035, 15, 1'b0, 1'b0, 2, 1'b0);
      settle();
      chk("R11 no mark stays in standby", stat(), expv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h099));
      send_char(1'b0, 9'h0A5, 15, 1'b1, 1'b0, 2, 1'b0);
      settle();
      chk("R11 8-bit mark wakes", stat(), expv(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0A5));
      rd();

      // R11 address-mark wake, 9-bit: bit 7 alone is no mark
      @(negedge clk) standby_req = 1'b1;
      @(negedge clk) standby_req = 1'b0;
      send_char(1'b1, 9'h0FF, 15, 1'b1, 1'b0, 2, 1'b0);
      settle();
      chk("R11 9-bit bit7 is no mark", stat(), expv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5));
      send_char(1'b1, 9'h103, 15, 1'b1, 1'b0, 2, 1'b0);
      settle();
      chk("R11 9-bit mark wakes", stat(), expv(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h103));
      rd();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule